// File: doc/BRIEF.md
# Vertical Blank Flag and NMI Generator

This block keeps the raster position of a video timing generator: a dot counter and a scanline counter clocked by the pixel clock. From that position it sets a vertical-blank status flag when the first blanking scanline starts and clears it just before the next frame starts. A CPU reads the flag through a one-cycle read strobe. The block gates the flag with an interrupt-enable bit to form an active-low NMI request.

All races are settled at single-dot precision. The read strobe is taken on the pixel-clock cycle in which the access happens, not at the end of a CPU instruction. A read that meets the edge which would set the flag returns 0 and cancels the flag for that frame. Every odd frame with background rendering on is one dot shorter, because the final dot of the last scanline is dropped.

The geometry is set by parameters: DOTS dots per line (default 341), LINES lines per frame (default 262) and VBL_LINE, the first blanking line (default 241). The last line, LINES-1, is the pre-render line.

Top module: `vblank_flag_gen`

## Requirements
- R1: The dot count runs 0 to DOTS-1 and wraps to 0. The line count steps by one at each dot wrap and wraps from LINES-1 to 0.
- R2: With no read, the flag is 0 while the position is (VBL_LINE-1, DOTS-1) and 1 from (VBL_LINE, 0).
- R3: The flag stays set through dot 0 of line LINES-1 and is 0 from dot 1 of that line.
- R4: nmi_n_o is low exactly when the flag and nmi_en_i are both 1. Raising nmi_en_i while the flag is set drives it low in the same cycle, and lowering nmi_en_i releases it.
- R5: A strobed read loads rd_data_o with the flag in bit 7 and zeros in bits 6..0. The new value is visible from the dot after the strobe and holds until the next read.
- R6: A read clears the flag from the following dot on, which releases nmi_n_o.
- R7: A read strobed in the cycle at (VBL_LINE-1, DOTS-1) returns 0x00, and neither the flag nor nmi_n_o asserts for the rest of that frame.
- R8: A frame-parity bit toggles at every wrap to line 0. When it is odd and bg_en_i is 1, the position goes from (LINES-1, DOTS-2) straight to (0, 0).
- R9: Even frames, and odd frames with bg_en_i at 0, keep dot DOTS-1 of line LINES-1.
- R10: Reset makes the parity even, so the first frame after reset has full length and the next odd frame is shortened.
- R11: While rst_i (synchronous, active high) is sampled high, the position goes to (0, 0), the flag and rd_data_o to 0, and nmi_n_o to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock, one dot per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| bg_en_i | input | 1 | Background rendering enabled; arms the odd-frame dot skip |
| nmi_en_i | input | 1 | Interrupt enable gating the flag onto nmi_n_o |
| rd_stb_i | input | 1 | Status read taking place in this dot |
| rd_data_o | output | 8 | Status value of the last read, flag in bit 7 |
| nmi_n_o | output | 1 | Active-low NMI request |
| dot_o | output | DOT_W (9) | Current dot within the line |
| line_o | output | LINE_W (9) | Current scanline |

## Verification
The flag changes on the clock edge that leaves the trigger dot, so each flag result is checked in the middle of the first dot that should show it. Because nmi_n_o is the flag gated by the enable, an enable change is checked one time step after it is driven, in the same dot. A read result is due one edge after the strobe, and the bench checks it in the dot after the strobe cycle. Odd-frame skips and full-length frames are checked by stepping one edge from (LINES-1, DOTS-2) and comparing the position.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
    // Default raster geometry
    localparam int DEF_DOTS     = 341;
    localparam int DEF_LINES    = 262;
    localparam int DEF_VBL_LINE = 241;

    // Status word returned to the reader
    localparam int STAT_W       = 8;
    localparam int FLAG_BIT     = STAT_W - 1;

    typedef logic [STAT_W-1:0] stat_word_t;

    typedef struct packed {
        logic       flag;
        stat_word_t rd_data;
    } status_t;
endpackage

// File: rtl/vbl_raster.sv
module vbl_raster #(
    parameter int DOTS     = vbl_pkg::DEF_DOTS,
    parameter int LINES    = vbl_pkg::DEF_LINES,
    parameter int VBL_LINE = vbl_pkg::DEF_VBL_LINE,
    parameter int DOT_W    = $clog2(DOTS),
    parameter int LINE_W   = $clog2(LINES)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bg_en_i,
    output logic [DOT_W-1:0]  dot_o,
    output logic [LINE_W-1:0] line_o,
    output logic              odd_o,
    output logic              set_pos_o,
    output logic              clr_pos_o
);
    localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS - 1);
    localparam logic [DOT_W-1:0]  DOT_SKIP  = DOT_W'(DOTS - 2);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
    localparam logic [LINE_W-1:0] LINE_PRE  = LINE_W'(VBL_LINE - 1);

    typedef struct packed {
        logic [DOT_W-1:0]  dot;
        logic [LINE_W-1:0] line;
        logic              odd;
    } raster_t;

    raster_t r_d, r_q;
    logic    line_end;
    logic    skip_now;

    always_comb begin
        r_d      = r_q;
        skip_now = r_q.odd && bg_en_i && (r_q.line == LINE_LAST) && (r_q.dot == DOT_SKIP);
        line_end = (r_q.dot == DOT_LAST) || skip_now;
        if (line_end) begin
            r_d.dot = '0;
            if (r_q.line == LINE_LAST) begin
                r_d.line = '0;
                r_d.odd  = ~r_q.odd;
            end else begin
                r_d.line = r_q.line + 1'b1;
            end
        end else begin
            r_d.dot = r_q.dot + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign dot_o     = r_q.dot;
    assign line_o    = r_q.line;
    assign odd_o     = r_q.odd;
    // Edge leaving this dot enters the first blanking dot
    assign set_pos_o = (r_q.line == LINE_PRE) && (r_q.dot == DOT_LAST);
    // Edge leaving this dot enters dot 1 of the pre-render line
    assign clr_pos_o = (r_q.line == LINE_LAST) && (r_q.dot == '0);
endmodule

// File: rtl/vbl_status.sv
module vbl_status (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      set_pos_i,
    input  logic                      clr_pos_i,
    input  logic                      rd_stb_i,
    output logic                      flag_o,
    output vbl_pkg::stat_word_t       rd_data_o
);
    import vbl_pkg::*;

    status_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_stb_i) begin
            s_d.rd_data           = '0;
            s_d.rd_data[FLAG_BIT] = s_q.flag;
        end
        // A read on the set edge wins: flag_q is still 0 there, so the
        // returned value is 0 and the flag is never raised this frame.
        if (set_pos_i && !rd_stb_i) s_d.flag = 1'b1;
        if (clr_pos_i || rd_stb_i)  s_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign flag_o    = s_q.flag;
    assign rd_data_o = s_q.rd_data;
endmodule

// File: rtl/vblank_flag_gen.sv
module vblank_flag_gen #(
    parameter int DOTS     = vbl_pkg::DEF_DOTS,
    parameter int LINES    = vbl_pkg::DEF_LINES,
    parameter int VBL_LINE = vbl_pkg::DEF_VBL_LINE,
    parameter int DOT_W    = $clog2(DOTS),
    parameter int LINE_W   = $clog2(LINES)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bg_en_i,
    input  logic              nmi_en_i,
    input  logic              rd_stb_i,
    output logic [7:0]        rd_data_o,
    output logic              nmi_n_o,
    output logic [DOT_W-1:0]  dot_o,
    output logic [LINE_W-1:0] line_o
);
    logic odd_w;
    logic set_pos_w;
    logic clr_pos_w;
    logic flag_w;

    vbl_raster #(
        .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE),
        .DOT_W(DOT_W), .LINE_W(LINE_W)
    ) u_raster (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .bg_en_i  (bg_en_i),
        .dot_o    (dot_o),
        .line_o   (line_o),
        .odd_o    (odd_w),
        .set_pos_o(set_pos_w),
        .clr_pos_o(clr_pos_w)
    );

    vbl_status u_status (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .set_pos_i(set_pos_w),
        .clr_pos_i(clr_pos_w),
        .rd_stb_i (rd_stb_i),
        .flag_o   (flag_w),
        .rd_data_o(rd_data_o)
    );

    // Level-sensitive gate: a rise on either side while the other is high
    // pulls the request low in that same dot.
    assign nmi_n_o = ~(flag_w & nmi_en_i);
endmodule

// File: rtl/vbl_checker.sv
module vbl_checker #(
    parameter int DOTS     = vbl_pkg::DEF_DOTS,
    parameter int LINES    = vbl_pkg::DEF_LINES,
    parameter int VBL_LINE = vbl_pkg::DEF_VBL_LINE,
    parameter int DOT_W    = $clog2(DOTS),
    parameter int LINE_W   = $clog2(LINES)
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              bg_en_i,
    input logic              rd_stb_i,
    input logic [7:0]        rd_data_i,
    input logic              nmi_n_i,
    input logic [DOT_W-1:0]  dot_i,
    input logic [LINE_W-1:0] line_i,
    input logic              odd_i,
    input logic              flag_i
);
    localparam logic [DOT_W-1:0]  DL = DOT_W'(DOTS - 1);
    localparam logic [DOT_W-1:0]  DS = DOT_W'(DOTS - 2);
    localparam logic [LINE_W-1:0] LL = LINE_W'(LINES - 1);
    localparam logic [LINE_W-1:0] LP = LINE_W'(VBL_LINE - 1);

    assert_dot_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        dot_i <= DL);
    assert_dot_wrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (dot_i == DL) |=> (dot_i == '0));
    assert_line_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (dot_i == DL && line_i != LL) |=> (line_i == $past(line_i) + 1'b1));
    assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (line_i == LP && dot_i == DL && !rd_stb_i) |=> flag_i);
    assert_flag_clr_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (line_i == LL && dot_i == '0) |=> !flag_i);
    assert_nmi_idle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !flag_i |-> nmi_n_i);
    assert_rdata_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_stb_i |=> $stable(rd_data_i));
    assert_read_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_stb_i |=> !flag_i);
    assert_suppress_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_stb_i && line_i == LP && dot_i == DL) |=> (!flag_i && rd_data_i == 8'h00));
    assert_odd_skip_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (odd_i && bg_en_i && line_i == LL && dot_i == DS) |=> (line_i == '0 && dot_i == '0));
    assert_parity_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (line_i == LL && dot_i == DL) |=> (odd_i != $past(odd_i)));
endmodule

bind vblank_flag_gen vbl_checker #(
    .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .bg_en_i  (bg_en_i),
    .rd_stb_i (rd_stb_i),
    .rd_data_i(rd_data_o),
    .nmi_n_i  (nmi_n_o),
    .dot_i    (dot_o),
    .line_i   (line_o),
    .odd_i    (odd_w),
    .flag_i   (flag_w)
);

// File: tb/sim_vblank_flag_gen.sv
module sim_vblank_flag_gen;
    // Small geometry keeps several full frames short
    localparam int DOTS     = 21;
    localparam int LINES    = 12;
    localparam int VBL_LINE = 8;
    localparam int DOT_W    = $clog2(DOTS);
    localparam int LINE_W   = $clog2(LINES);
    localparam int LAST     = LINES - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bg  = 1'b1;
    logic en  = 1'b1;
    logic rd  = 1'b0;
    logic [7:0]        rd_data;
    logic              nmi_n;
    logic [DOT_W-1:0]  dot;
    logic [LINE_W-1:0] line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vblank_flag_gen #(.DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE)) u0 (
        .clk_i(clk), .rst_i(rst), .bg_en_i(bg), .nmi_en_i(en), .rd_stb_i(rd),
        .rd_data_o(rd_data), .nmi_n_o(nmi_n), .dot_o(dot), .line_o(line)
    );

    typedef struct packed {
        logic [4:0] ln;
        logic [4:0] dt;
        logic       rd;
        logic       en;
        logic       bg;
        logic       exp_nmi_n;
        logic [7:0] exp_rd;
        logic [3:0] req;
    } vec_t;

    // line, dot, read, nmi enable, bg enable, expected nmi_n, expected rd_data, requirement
    localparam vec_t VEC [12] = '{
        '{5'd7,  5'd20, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 4'd7},  // R7 read on set edge
        '{5'd8,  5'd0,  1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'd7},  // R7 returned 0, no flag
        '{5'd9,  5'd0,  1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'd7},  // R7 still quiet
        '{5'd11, 5'd0,  1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'd7},  // R7 quiet to frame end
        '{5'd11, 5'd20, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'd9},  // R9 even frame keeps last dot
        '{5'd7,  5'd20, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'd2},  // R2 before set
        '{5'd8,  5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'd2},  // R2 set
        '{5'd8,  5'd5,  1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 4'd4},  // R4 disable releases
        '{5'd8,  5'd6,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'd4},  // R4 enable asserts
        '{5'd11, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'd3},  // R3 still set
        '{5'd11, 5'd1,  1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'd3},  // R3 cleared
        '{5'd11, 5'd19, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'd8}   // R8 before skip
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        rd = 1'b0;
        #1;
    endtask

    task automatic goto(input int l, input int d);
        while (!(int'(line) == l && int'(dot) == d)) step();
    endtask

    task automatic chk_pos(input int l, input int d, input string req);
        chk(int'(line) == l && int'(dot) == d, req,
            int'(line) * 1000 + int'(dot), l * 1000 + d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        chk_pos(0, 0, "R11");
        chk(nmi_n == 1'b1, "R11", int'(nmi_n), 1);
        chk(rd_data == 8'h00, "R11", int'(rd_data), 0);
        rst = 1'b0;

        // R1 dot wrap into next line
        goto(0, DOTS - 1);
        step();
        chk_pos(1, 0, "R1");

        // frames 0 (even) and 1 (odd, bg on)
        for (int i = 0; i < 12; i++) begin
            goto(int'(VEC[i].ln), int'(VEC[i].dt));
            rd = VEC[i].rd;
            en = VEC[i].en;
            bg = VEC[i].bg;
            #1;
            chk(nmi_n == VEC[i].exp_nmi_n, $sformatf("R%0d nmi", VEC[i].req),
                int'(nmi_n), int'(VEC[i].exp_nmi_n));
            chk(rd_data == VEC[i].exp_rd, $sformatf("R%0d data", VEC[i].req),
                int'(rd_data), int'(VEC[i].exp_rd));
        end
        step();
        chk_pos(0, 0, "R8");  // odd frame skipped last dot

        // frame 2 (even): normal read
        goto(VBL_LINE, 3);
        chk(nmi_n == 1'b0, "R2", int'(nmi_n), 0);
        rd = 1'b1;
        step();
        chk(rd_data == 8'h80, "R5", int'(rd_data), 128);
        chk(nmi_n == 1'b1, "R6", int'(nmi_n), 1);
        goto(VBL_LINE, 10);
        rd = 1'b1;
        step();
        chk(rd_data == 8'h00, "R5", int'(rd_data), 0);
        goto(LAST, DOTS - 2);
        step();
        chk_pos(LAST, DOTS - 1, "R9");
        step();
        chk_pos(0, 0, "R1");

        // frame 3 (odd, bg off): full length
        bg = 1'b0;
        goto(LAST, DOTS - 2);
        step();
        chk_pos(LAST, DOTS - 1, "R9");
        bg = 1'b1;

        // frame 4 (even): read flag, then reset mid-frame
        goto(VBL_LINE, 2);
        rd = 1'b1;
        step();
        chk(rd_data == 8'h80, "R5", int'(rd_data), 128);
        goto(VBL_LINE + 1, 4);
        rst = 1'b1;
        step();
        step();
        chk_pos(0, 0, "R11");
        chk(rd_data == 8'h00, "R11", int'(rd_data), 0);
        chk(nmi_n == 1'b1, "R11", int'(nmi_n), 1);
        rst = 1'b0;

        // R10 parity cleared: first frame full, next odd one short
        goto(LAST, DOTS - 2);
        step();
        chk_pos(LAST, DOTS - 1, "R10");
        step();
        goto(LAST, DOTS - 2);
        step();
        chk_pos(0, 0, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule